// File: doc/BRIEF.md
# CAN Interframe and Error-Field Sequencer

This block follows a CAN bus bit by bit through the stretch that comes after a data or remote frame. That stretch covers the three-bit intermission, the idle bus, error frames and overload frames. A frame receiver drives it with one sampled bus level per bit-time strobe. The receiver also gives it a pulse on the last end-of-frame bit and a pulse when it detects an error. A fault-confinement unit supplies the error-passive status. In return the block reports which bus field is in progress and asks the transmitter to drive dominant while this node's own flag is being sent. It also tells the frame logic when a new start of frame may be sent, and it pulses when a delimiter breaks its fixed form or when an overload condition is seen.

Error frames can start at any bit, including inside a frame or inside the intermission. An overload frame can cut into the first two intermission bits. A dominant bit in the third intermission bit is taken as the next start of frame. Every delimiter is checked for its recessive form, and a dominant level on the last delimiter bit is treated as an overload condition rather than an error. At most two overload frames may run back to back.

Top module: `can_ifs_seq`

## Requirements
- R1: Reset (synchronous, active high) gives field code 0 (wait-for-idle) with tx_dom, bus_idle, sof_ok, form_err and ovl_det low. The block then leaves code 0 for code 1 (idle) only after 11 consecutive recessive bits. A dominant bit restarts that run.
- R2: The field state changes only on a clock where bit_stb is high. frame_end and err_det are sampled only with bit_stb.
- R3: In code 2 (in frame), frame_end moves to code 3 (intermission). Three recessive bits there lead to code 1, and sof_ok and bus_idle are low until then.
- R4: A dominant bit on the third intermission bit moves to code 2 (start of frame) with no ovl_det pulse.
- R5: A dominant bit on intermission bit 1 or 2 moves to code 5 (overload flag) and pulses ovl_det for one clock. tx_dom is high for the 6 flag bits that follow.
- R6: err_det in any state other than code 4 moves to code 4 (error flag) for the next 6 bits. tx_dom is high during those bits when err_passive was low at entry, and low when it was high.
- R7: After the 6 flag bits the block is in code 6 (flag tail), which absorbs dominant bits. The first recessive bit enters code 7 (delimiter) as delimiter bit 1. After the 8th recessive delimiter bit the block returns to code 3.
- R8: A dominant bit on delimiter bits 1 to 7 pulses form_err for one clock and moves to code 4.
- R9: A dominant bit on the 8th delimiter bit raises no form_err. It is accepted as an overload (code 5, ovl_det pulse).
- R10: Only 2 overload frames are accepted in a row. A third overload condition pulses form_err, moves to code 4 and gives no ovl_det. The overload count is cleared by frame_end and by entry to an error flag.
- R11: bus_idle and sof_ok are high only in code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-clock strobe per sampled bus bit |
| rx_bit | input | 1 | Sampled bus level, 1 = recessive |
| frame_end | input | 1 | Last end-of-frame bit of a received frame, valid with bit_stb |
| err_det | input | 1 | Error detected by the receiver, valid with bit_stb |
| err_passive | input | 1 | Node is error passive |
| field_o | output | 3 | Current field code (0 wait, 1 idle, 2 frame, 3 intermission, 4 error flag, 5 overload flag, 6 flag tail, 7 delimiter) |
| tx_dom | output | 1 | Request to drive dominant for a flag bit |
| bus_idle | output | 1 | Bus is idle |
| sof_ok | output | 1 | A start of frame may be sent |
| form_err | output | 1 | One-clock pulse on a delimiter form error or a rejected third overload |
| ovl_det | output | 1 | One-clock pulse on an accepted overload condition |

## Verification
The hardest case to reach from the ports is the rejected third overload. It needs a frame end and then two complete overload frames, each with a 6-bit flag, some absorbed dominant tail bits and a full 8-bit delimiter. Only after that can a dominant bit on an early intermission bit arrive. The bench builds this chain in one directed task, checking the field code at every stage. It then confirms that a fresh frame end makes an overload acceptable again. The last-bit delimiter exception gets the same treatment: the bench counts exactly seven recessive delimiter bits before it applies the dominant bit.

// File: rtl/can_ifs_pkg.sv
package can_ifs_pkg;

    localparam logic LVL_REC = 1'b1;
    localparam logic LVL_DOM = 1'b0;

    typedef enum logic [2:0] {
        FLD_WAIT    = 3'd0,
        FLD_IDLE    = 3'd1,
        FLD_FRAME   = 3'd2,
        FLD_INTERM  = 3'd3,
        FLD_ERRFLAG = 3'd4,
        FLD_OVLFLAG = 3'd5,
        FLD_TAIL    = 3'd6,
        FLD_DELIM   = 3'd7
    } field_e;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_CLR  = 2'd1,
        CNT_INC  = 2'd2,
        CNT_ONE  = 2'd3
    } cnt_op_e;

    typedef struct packed {
        field_e  nxt;
        cnt_op_e op;
        logic    ovl_inc;
        logic    ovl_clr;
        logic    form_p;
        logic    ovl_p;
        logic    latch_psv;
    } step_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic step_t step_hold(input field_e cur);
        step_t s;
        s.nxt       = cur;
        s.op        = CNT_HOLD;
        s.ovl_inc   = 1'b0;
        s.ovl_clr   = 1'b0;
        s.form_p    = 1'b0;
        s.ovl_p     = 1'b0;
        s.latch_psv = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/can_ifs_bitcnt.sv
module can_ifs_bitcnt
    import can_ifs_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_op_e          op,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case (op)
                CNT_CLR:  cnt <= '0;
                CNT_INC:  cnt <= cnt + 1'b1;
                CNT_ONE:  cnt <= CNT_W'(1);
                default:  cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/can_ifs_ovl_guard.sv
module can_ifs_ovl_guard #(
    parameter int MAX_OVL = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic clr,
    output logic ovl_ok
);

    localparam int OW = $clog2(MAX_OVL + 1);
    localparam logic [OW-1:0] LIMIT = OW'(MAX_OVL);

    logic [OW-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= '0;
        end else if (clr) begin
            seen <= '0;
        end else if (inc && (seen != LIMIT)) begin
            seen <= seen + 1'b1;
        end
    end

    assign ovl_ok = (seen < LIMIT);

endmodule

// File: rtl/can_ifs_fsm.sv
module can_ifs_fsm
    import can_ifs_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int INTERM_BITS = 3,
    parameter int FLAG_BITS   = 6,
    parameter int DELIM_BITS  = 8,
    parameter int IDLE_RUN    = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_stb,
    input  logic             rx_bit,
    input  logic             frame_end,
    input  logic             err_det,
    input  logic             err_passive,
    input  logic [CNT_W-1:0] cnt,
    input  logic             ovl_ok,
    output field_e           field,
    output step_t            step,
    output logic             flag_psv,
    output logic             form_p_q,
    output logic             ovl_p_q
);

    localparam logic [CNT_W-1:0] LAST_INT  = CNT_W'(INTERM_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_FLAG = CNT_W'(FLAG_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_DEL  = CNT_W'(DELIM_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_RUN  = CNT_W'(IDLE_RUN - 1);

    logic rec;
    assign rec = (rx_bit == LVL_REC);

    function automatic step_t to_error(input field_e cur, input logic form);
        step_t s;
        s           = step_hold(cur);
        s.nxt       = FLD_ERRFLAG;
        s.op        = CNT_CLR;
        s.ovl_clr   = 1'b1;
        s.form_p    = form;
        s.latch_psv = 1'b1;
        return s;
    endfunction

    function automatic step_t to_overload(input field_e cur, input logic ok);
        step_t s;
        if (ok) begin
            s         = step_hold(cur);
            s.nxt     = FLD_OVLFLAG;
            s.op      = CNT_CLR;
            s.ovl_inc = 1'b1;
            s.ovl_p   = 1'b1;
        end else begin
            s = to_error(cur, 1'b1);
        end
        return s;
    endfunction

    always_comb begin
        step = step_hold(field);
        if (bit_stb) begin
            if (err_det && (field != FLD_ERRFLAG)) begin
                step = to_error(field, 1'b0);
            end else begin
                case (field)
                    FLD_WAIT: begin
                        if (!rec) begin
                            step.op = CNT_CLR;
                        end else if (cnt == LAST_RUN) begin
                            step.nxt = FLD_IDLE;
                            step.op  = CNT_CLR;
                        end else begin
                            step.op = CNT_INC;
                        end
                    end
                    FLD_IDLE: begin
                        if (!rec) begin
                            step.nxt = FLD_FRAME;
                            step.op  = CNT_CLR;
                        end
                    end
                    FLD_FRAME: begin
                        if (frame_end) begin
                            step.nxt     = FLD_INTERM;
                            step.op      = CNT_CLR;
                            step.ovl_clr = 1'b1;
                        end
                    end
                    FLD_INTERM: begin
                        if (rec) begin
                            if (cnt == LAST_INT) begin
                                step.nxt = FLD_IDLE;
                                step.op  = CNT_CLR;
                            end else begin
                                step.op = CNT_INC;
                            end
                        end else if (cnt == LAST_INT) begin
                            step.nxt = FLD_FRAME;
                            step.op  = CNT_CLR;
                        end else begin
                            step = to_overload(field, ovl_ok);
                        end
                    end
                    FLD_ERRFLAG, FLD_OVLFLAG: begin
                        if (cnt == LAST_FLAG) begin
                            step.nxt = FLD_TAIL;
                            step.op  = CNT_CLR;
                        end else begin
                            step.op = CNT_INC;
                        end
                    end
                    FLD_TAIL: begin
                        if (rec) begin
                            step.nxt = FLD_DELIM;
                            step.op  = CNT_ONE;
                        end
                    end
                    FLD_DELIM: begin
                        if (rec) begin
                            if (cnt == LAST_DEL) begin
                                step.nxt = FLD_INTERM;
                                step.op  = CNT_CLR;
                            end else begin
                                step.op = CNT_INC;
                            end
                        end else if (cnt == LAST_DEL) begin
                            step = to_overload(field, ovl_ok);
                        end else begin
                            step = to_error(field, 1'b1);
                        end
                    end
                    default: step = step_hold(field);
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            field    <= FLD_WAIT;
            flag_psv <= 1'b0;
            form_p_q <= 1'b0;
            ovl_p_q  <= 1'b0;
        end else begin
            field    <= step.nxt;
            form_p_q <= step.form_p;
            ovl_p_q  <= step.ovl_p;
            if (step.latch_psv) begin
                flag_psv <= err_passive;
            end
        end
    end

endmodule

// File: rtl/can_ifs_seq.sv
module can_ifs_seq
    import can_ifs_pkg::*;
#(
    parameter int INTERM_BITS = 3,
    parameter int FLAG_BITS   = 6,
    parameter int DELIM_BITS  = 8,
    parameter int IDLE_RUN    = 11,
    parameter int MAX_OVL     = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_stb,
    input  logic       rx_bit,
    input  logic       frame_end,
    input  logic       err_det,
    input  logic       err_passive,
    output logic [2:0] field_o,
    output logic       tx_dom,
    output logic       bus_idle,
    output logic       sof_ok,
    output logic       form_err,
    output logic       ovl_det
);

    localparam int LONGEST = max_of(max_of(INTERM_BITS, FLAG_BITS),
                                    max_of(DELIM_BITS, IDLE_RUN));
    localparam int CNT_W   = $clog2(LONGEST + 1);

    field_e           field;
    step_t            step;
    logic [CNT_W-1:0] cnt;
    logic             ovl_ok;
    logic             flag_psv;

    can_ifs_fsm #(
        .CNT_W      (CNT_W),
        .INTERM_BITS(INTERM_BITS),
        .FLAG_BITS  (FLAG_BITS),
        .DELIM_BITS (DELIM_BITS),
        .IDLE_RUN   (IDLE_RUN)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .bit_stb    (bit_stb),
        .rx_bit     (rx_bit),
        .frame_end  (frame_end),
        .err_det    (err_det),
        .err_passive(err_passive),
        .cnt        (cnt),
        .ovl_ok     (ovl_ok),
        .field      (field),
        .step       (step),
        .flag_psv   (flag_psv),
        .form_p_q   (form_err),
        .ovl_p_q    (ovl_det)
    );

    can_ifs_bitcnt #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk(clk),
        .rst(rst),
        .op (step.op),
        .cnt(cnt)
    );

    can_ifs_ovl_guard #(
        .MAX_OVL(MAX_OVL)
    ) u_ovl (
        .clk   (clk),
        .rst   (rst),
        .inc   (step.ovl_inc),
        .clr   (step.ovl_clr),
        .ovl_ok(ovl_ok)
    );

    assign field_o  = field;
    assign tx_dom   = (field == FLD_OVLFLAG) || ((field == FLD_ERRFLAG) && !flag_psv);
    assign bus_idle = (field == FLD_IDLE);
    assign sof_ok   = (field == FLD_IDLE);

endmodule

// File: rtl/can_ifs_seq_chk.sv
module can_ifs_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_stb,
    input logic       err_det,
    input logic [2:0] field_o,
    input logic       tx_dom,
    input logic       bus_idle,
    input logic       sof_ok,
    input logic       form_err,
    input logic       ovl_det
);

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !bit_stb |=> $stable(field_o)); // R2

    AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_idle) |-> ($past(field_o) == 3'd3 || $past(field_o) == 3'd0)); // R3

    AST_SOF_IN_IDLE: assert property (@(posedge clk) disable iff (rst)
        sof_ok |-> field_o == 3'd1); // R11

    AST_OVL_ENTERS_FLAG: assert property (@(posedge clk) disable iff (rst)
        ovl_det |-> field_o == 3'd5); // R5

    AST_FORM_TO_ERROR: assert property (@(posedge clk) disable iff (rst)
        form_err |-> field_o == 3'd4); // R8

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(form_err && ovl_det)); // R10

    AST_TX_IN_FLAG: assert property (@(posedge clk) disable iff (rst)
        tx_dom |-> (field_o == 3'd4 || field_o == 3'd5)); // R6

    AST_ERR_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && err_det && field_o != 3'd4) |=> field_o == 3'd4); // R6

endmodule

bind can_ifs_seq can_ifs_seq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .bit_stb (bit_stb),
    .err_det (err_det),
    .field_o (field_o),
    .tx_dom  (tx_dom),
    .bus_idle(bus_idle),
    .sof_ok  (sof_ok),
    .form_err(form_err),
    .ovl_det (ovl_det)
);

// File: tb/can_ifs_seq_test.sv
module can_ifs_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_stb = 1'b0;
    logic       rx_bit = 1'b1;
    logic       frame_end = 1'b0;
    logic       err_det = 1'b0;
    logic       err_passive = 1'b0;
    logic [2:0] field_o;
    logic       tx_dom, bus_idle, sof_ok, form_err, ovl_det;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    can_ifs_seq uut (
        .clk        (clk),
        .rst        (rst),
        .bit_stb    (bit_stb),
        .rx_bit     (rx_bit),
        .frame_end  (frame_end),
        .err_det    (err_det),
        .err_passive(err_passive),
        .field_o    (field_o),
        .tx_dom     (tx_dom),
        .bus_idle   (bus_idle),
        .sof_ok     (sof_ok),
        .form_err   (form_err),
        .ovl_det    (ovl_det)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic bit_t(input logic rx, input logic fe, input logic ed);
        rx_bit    = rx;
        frame_end = fe;
        err_det   = ed;
        bit_stb   = 1'b1;
        @(negedge clk);
        bit_stb   = 1'b0;
        frame_end = 1'b0;
        err_det   = 1'b0;
    endtask

    task automatic bits(input logic rx, input int n);
        for (int i = 0; i < n; i++) bit_t(rx, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        err_passive = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic go_interm();
        do_reset();
        bits(1'b1, 11);
        bit_t(1'b0, 1'b0, 1'b0);
        bits(1'b1, 2);
        bit_t(1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "field after reset", field_o, 0);
        chk("R1", "tx_dom after reset", tx_dom, 0);
        chk("R1", "bus_idle after reset", bus_idle, 0);
        chk("R1", "sof_ok after reset", sof_ok, 0);
        chk("R1", "pulses after reset", form_err | ovl_det, 0);
    endtask

    task automatic t_wait_idle();
        do_reset();
        bits(1'b1, 10);
        chk("R1", "field after 10 recessive", field_o, 0);
        bit_t(1'b0, 1'b0, 1'b0);
        bits(1'b1, 10);
        chk("R1", "run restarted by dominant", field_o, 0);
        bits(1'b1, 1);
        chk("R1", "field after 11 recessive", field_o, 1);
        chk("R11", "bus_idle in idle", bus_idle, 1);
        chk("R11", "sof_ok in idle", sof_ok, 1);
    endtask

    task automatic t_no_strobe();
        do_reset();
        bits(1'b1, 11);
        rx_bit = 1'b0;
        repeat (5) @(negedge clk);
        chk("R2", "idle held without strobe", field_o, 1);
        bit_t(1'b0, 1'b0, 1'b0);
        frame_end = 1'b1;
        err_det = 1'b1;
        repeat (3) @(negedge clk);
        frame_end = 1'b0;
        err_det = 1'b0;
        chk("R2", "frame held without strobe", field_o, 2);
    endtask

    task automatic t_interm();
        do_reset();
        bits(1'b1, 11);
        bit_t(1'b0, 1'b0, 1'b0);
        chk("R3", "start of frame", field_o, 2);
        bits(1'b1, 3);
        chk("R3", "still in frame", field_o, 2);
        bit_t(1'b1, 1'b1, 1'b0);
        chk("R3", "intermission entered", field_o, 3);
        chk("R11", "sof_ok low in intermission", sof_ok, 0);
        bits(1'b1, 2);
        chk("R3", "after 2 intermission bits", field_o, 3);
        chk("R3", "bus_idle low before end", bus_idle, 0);
        bits(1'b1, 1);
        chk("R3", "idle after 3 bits", field_o, 1);
        chk("R3", "sof_ok after intermission", sof_ok, 1);
    endtask

    task automatic t_sof_third();
        go_interm();
        bits(1'b1, 2);
        bit_t(1'b0, 1'b0, 1'b0);
        chk("R4", "dominant on bit 3 is frame", field_o, 2);
        chk("R4", "no overload pulse", ovl_det, 0);
    endtask

    task automatic t_overload();
        go_interm();
        bit_t(1'b0, 1'b0, 1'b0);
        chk("R5", "overload flag entered", field_o, 5);
        chk("R5", "ovl_det pulse", ovl_det, 1);
        bits(1'b0, 5);
        chk("R5", "tx_dom during flag", tx_dom, 1);
        chk("R5", "flag after 5 bits", field_o, 5);
        bits(1'b0, 1);
        chk("R7", "tail after 6 flag bits", field_o, 6);
        chk("R5", "tx_dom released", tx_dom, 0);
        bits(1'b0, 3);
        chk("R7", "tail absorbs dominant", field_o, 6);
        bits(1'b1, 7);
        chk("R7", "delimiter after 7 recessive", field_o, 7);
        bits(1'b1, 1);
        chk("R7", "intermission after delimiter", field_o, 3);
    endtask

    task automatic t_err_active();
        go_interm();
        bits(1'b1, 3);
        bit_t(1'b0, 1'b0, 1'b0);
        bit_t(1'b1, 1'b0, 1'b1);
        chk("R6", "error flag mid-frame", field_o, 4);
        chk("R6", "active flag drives", tx_dom, 1);
        bits(1'b0, 5);
        chk("R6", "still flag after 5", field_o, 4);
        bits(1'b0, 1);
        chk("R6", "tail after 6 flag bits", field_o, 6);
        bits(1'b1, 8);
        chk("R7", "intermission after error delimiter", field_o, 3);
    endtask

    task automatic t_err_passive();
        go_interm();
        bit_t(1'b1, 1'b0, 0);
        err_passive = 1'b1;
        bit_t(1'b1, 1'b0, 1'b1);
        chk("R6", "error in intermission", field_o, 4);
        chk("R6", "passive flag silent", tx_dom, 0);
        bits(1'b0, 6);
        chk("R7", "tail after passive flag", field_o, 6);
    endtask

    task automatic t_form();
        go_interm();
        bit_t(1'b1, 1'b0, 1'b1);
        bits(1'b0, 6);
        bits(1'b1, 3);
        chk("R8", "in delimiter", field_o, 7);
        bit_t(1'b0, 1'b0, 1'b0);
        chk("R8", "form_err pulse", form_err, 1);
        chk("R8", "new error flag", field_o, 4);
        bit_t(1'b0, 1'b0, 1'b0);
        chk("R8", "form_err one clock", form_err, 0);
    endtask

    task automatic t_last_bit();
        go_interm();
        bit_t(1'b1, 1'b0, 1'b1);
        bits(1'b0, 6);
        bits(1'b1, 7);
        bit_t(1'b0, 1'b0, 1'b0);
        chk("R9", "no form_err on last bit", form_err, 0);
        chk("R9", "overload on last bit", field_o, 5);
        chk("R9", "ovl_det on last bit", ovl_det, 1);
    endtask

    task automatic t_third();
        go_interm();
        for (int k = 0; k < 2; k++) begin
            bit_t(1'b1, 1'b0, 1'b0);
            bit_t(1'b0, 1'b0, 1'b0);
            chk("R10", "accepted overload", ovl_det, 1);
            bits(1'b0, 8);
            bits(1'b1, 8);
            chk("R10", "back in intermission", field_o, 3);
        end
        bit_t(1'b0, 1'b0, 1'b0);
        chk("R10", "third overload rejected", ovl_det, 0);
        chk("R10", "third gives form_err", form_err, 1);
        chk("R10", "third gives error flag", field_o, 4);
        bits(1'b0, 6);
        bits(1'b1, 8);
        bits(1'b1, 3);
        bit_t(1'b0, 1'b0, 1'b0);
        bit_t(1'b1, 1'b1, 1'b0);
        bit_t(1'b0, 1'b0, 1'b0);
        chk("R10", "overload allowed after frame end", ovl_det, 1);
    endtask

    initial begin
        #1ms;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_wait_idle();
        t_no_strobe();
        t_interm();
        t_sof_third();
        t_overload();
        t_err_active();
        t_err_passive();
        t_form();
        t_last_bit();
        t_third();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule